// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable device-side model of a 2048-bit serial EEPROM on a three-wire bus made of chip select, serial clock and serial data in, plus one serial data output. A strap input picks the view of the storage. When it is high, the storage is 128 words of 16 bits. When it is low, it is 256 bytes of 8 bits. The bus lines are brought into the system clock domain through a synchronizer. The serial clock's rising edges are detected on the system clock, so the bus clock must run several times slower than the system clock.

A command starts when chip select goes high. The host then sends a start bit, a two-bit opcode and an address, followed by data for the store commands. The model supports single and sequential reads, word stores and erases, whole-array erase and store, and a program-enable latch. Every store or erase runs a program cycle whose length is set in system clocks. While that cycle runs, raising chip select again shows a busy/ready flag on the data output.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A command begins only after chip select rises. Zeros clocked in before the first 1 are skipped, and that first 1 is the start bit. The next two bits form the opcode, first bit sent as the high bit: 10 reads, 01 stores a location, 11 erases a location, and 00 is the special group.
- R2: With the strap high, the address has ADDR_W16 bits and the data has 16 bits. With the strap low, the address has ADDR_W16+1 bits and the data has 8 bits. Word a occupies byte 2a (its high half) and byte 2a+1 (its low half). Every bit is sent and returned most significant first.
- R3: After the last address bit of a read, the data output is driven and shows 0. Each later rising serial clock edge puts the next data bit on the output, starting with the MSB.
- R4: A read keeps going while chip select stays high. It moves to the next location with no extra 0 bit, and wraps from the last location to location 0.
- R5: After reset, programming is locked. Store, erase, whole-array erase and whole-array store then change nothing and start no program cycle.
- R6: In the 00 group, the two most significant address bits choose the command: 11 unlocks programming, 00 locks it, 01 erases the whole array and 10 stores to the whole array. A read works whether or not programming is locked.
- R7: A store command, while unlocked, writes its data into the addressed location.
- R8: Erasing a location sets all of its bits to 1. Erasing the whole array sets every bit to 1. After reset, the storage also reads all ones.
- R9: A whole-array store puts the supplied data into every location. In the byte view this is every byte; in the word view it is every word.
- R10: The program cycle starts after the last data bit (stores) or the last address bit (erases). It lasts exactly PROG_CYCLES system clocks. Any command sent while it runs is ignored.
- R11: The data output enable is low whenever chip select is low. If chip select is raised during a program cycle, the output shows 0 and then changes to 1 when the cycle ends.
- R12: Dropping chip select before a command has received all its bits cancels the command. No location changes and no program cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| scl | input | 1 | Serial clock; data is taken on its rising edges |
| di | input | 1 | Serial data in |
| org | input | 1 | Storage view strap: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data out |
| do_oe | output | 1 | Output enable for do_o |

## Verification
The bench builds the block with ADDR_W16 = 4 (32 bytes) and PROG_CYCLES = 60. With this size, every word can be stored and then read back in one sequential pass that runs past the wrap point. The same array is also read byte by byte to confirm where each half of a word lands. The short program cycle lets the bench sample the busy flag, time the change to ready, and send a command during the busy window. The whole-array commands and the enable latch are each exercised in both storage views.

// File: rtl/ee_pkg.sv
package ee_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_DAT,
      ST_RD,
      ST_STAT,
      ST_HOLD
   } ee_state_t;

   localparam logic [1:0] OP_SPECIAL = 2'b00;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_ERASE   = 2'b11;

   localparam logic [1:0] SUB_LOCK   = 2'b00;
   localparam logic [1:0] SUB_ERAALL = 2'b01;
   localparam logic [1:0] SUB_WRALL  = 2'b10;
   localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/ee_sync.sv
module ee_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ee_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
   parameter int CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] left;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("ee_prog_timer: CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left <= '0;
      else if (start)
         left <= CW'(CYCLES);
      else if (left != '0)
         left <= left - 1'b1;
   end

   assign busy = (left != '0);

endmodule

// File: rtl/ee_array.sv
module ee_array #(
   parameter int AW8 = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_one,
   input  logic           wr_all,
   input  logic           wide,
   input  logic [AW8-1:0] wr_adr,
   input  logic [15:0]    wr_dat,
   input  logic [AW8-1:0] rd_adr,
   output logic [7:0]     rd_byte
);

   localparam int BYTES = 1 << AW8;

   logic [7:0] cells [BYTES];

   generate
      for (genvar i = 0; i < BYTES; i++) begin : g_cell
         localparam logic [AW8-1:0] IDX = AW8'(i);
         logic       hit;
         logic [7:0] val;
         logic [7:0] cell_q;

         assign hit = wr_all |
                      (wr_one & (wide ? (wr_adr[AW8-2:0] == IDX[AW8-1:1])
                                      : (wr_adr == IDX)));
         assign val = wide ? (IDX[0] ? wr_dat[7:0] : wr_dat[15:8]) : wr_dat[7:0];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cell_q <= 8'hFF;
            else if (hit) cell_q <= val;
         end

         assign cells[i] = cell_q;
      end
   endgenerate

   assign rd_byte = cells[rd_adr];

endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
   import ee_pkg::*;
#(
   parameter int AW16 = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              scl_s,
   input  logic              di_s,
   input  logic              org,
   input  logic              busy,
   input  logic [7:0]        rd_byte,
   output logic [AW16:0]     rd_adr,
   output logic [AW16:0]     wr_adr,
   output logic [15:0]       wr_dat,
   output logic              wr_one,
   output logic              wr_all,
   output logic              wen,
   output logic              do_q,
   output logic              do_oe
);

   localparam int AW8 = AW16 + 1;
   localparam int CW  = 5;

   ee_state_t      st;
   logic [1:0]     opc;
   logic [CW-1:0]  cnt;
   logic [CW-1:0]  n_adr;
   logic [CW-1:0]  n_dat;
   logic [AW8-1:0] adr;
   logic [AW8-1:0] nxt_adr;
   logic [AW8-1:0] adr_inc;
   logic [15:0]    dat;
   logic [15:0]    nxt_dat;
   logic [3:0]     idx;
   logic [3:0]     idx_last;
   logic [1:0]     sub;
   logic           scl_prev;
   logic           scl_rise;
   logic           rd_bit;

   assign scl_rise = scl_s & ~scl_prev;
   assign n_adr    = org ? CW'(AW16) : CW'(AW8);
   assign n_dat    = org ? CW'(16) : CW'(8);
   assign idx_last = n_dat[3:0] - 4'd1;
   assign nxt_adr  = {adr[AW8-2:0], di_s};
   assign nxt_dat  = {dat[14:0], di_s};
   assign sub      = org ? nxt_adr[AW16-1:AW16-2] : nxt_adr[AW8-1:AW8-2];
   assign adr_inc  = org ? {1'b0, adr[AW16-1:0] + 1'b1} : adr + 1'b1;
   assign rd_adr   = org ? {adr[AW16-1:0], idx[3]} : adr;
   assign rd_bit   = rd_byte[3'd7 - idx[2:0]];
   assign wr_adr   = adr;
   assign wr_dat   = dat;
   assign do_oe    = cs_s & ((st == ST_RD) | (st == ST_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_prev <= 1'b0;
      else        scl_prev <= scl_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_OFF;
         opc    <= 2'b00;
         cnt    <= '0;
         adr    <= '0;
         dat    <= '0;
         idx    <= '0;
         wen    <= 1'b0;
         do_q   <= 1'b0;
         wr_one <= 1'b0;
         wr_all <= 1'b0;
      end else begin
         wr_one <= 1'b0;
         wr_all <= 1'b0;
         if (!cs_s) begin
            st   <= ST_OFF;
            do_q <= 1'b0;
         end else begin
            case (st)
               ST_OFF: begin
                  do_q <= 1'b0;
                  st   <= busy ? ST_STAT : ST_IDLE;
               end
               ST_IDLE: begin
                  if (scl_rise && di_s) begin
                     st  <= ST_OPC;
                     cnt <= '0;
                  end
               end
               ST_OPC: begin
                  if (scl_rise) begin
                     opc <= {opc[0], di_s};
                     if (cnt == CW'(1)) begin
                        st  <= ST_ADR;
                        cnt <= '0;
                        adr <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_ADR: begin
                  if (scl_rise) begin
                     adr <= nxt_adr;
                     if (cnt == n_adr - CW'(1)) begin
                        cnt <= '0;
                        dat <= '0;
                        idx <= '0;
                        st  <= ST_HOLD;
                        case (opc)
                           OP_READ: begin
                              st   <= ST_RD;
                              do_q <= 1'b0;
                           end
                           OP_WRITE: begin
                              if (wen) st <= ST_DAT;
                           end
                           OP_ERASE: begin
                              if (wen) begin
                                 wr_one <= 1'b1;
                                 dat    <= '1;
                              end
                           end
                           default: begin
                              case (sub)
                                 SUB_UNLOCK: wen <= 1'b1;
                                 SUB_LOCK:   wen <= 1'b0;
                                 SUB_ERAALL: begin
                                    if (wen) begin
                                       wr_all <= 1'b1;
                                       dat    <= '1;
                                    end
                                 end
                                 SUB_WRALL: begin
                                    if (wen) st <= ST_DAT;
                                 end
                                 default: ;
                              endcase
                           end
                        endcase
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_DAT: begin
                  if (scl_rise) begin
                     dat <= nxt_dat;
                     if (cnt == n_dat - CW'(1)) begin
                        st <= ST_HOLD;
                        if (opc == OP_WRITE) wr_one <= 1'b1;
                        else                 wr_all <= 1'b1;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     do_q <= rd_bit;
                     if (idx == idx_last) begin
                        idx <= '0;
                        adr <= adr_inc;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end
               end
               ST_STAT: do_q <= ~busy;
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
   parameter int ADDR_W16    = 7,
   parameter int PROG_CYCLES = 2000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic scl,
   input  logic di,
   input  logic org,
   output logic do_o,
   output logic do_oe
);

   localparam int AW8 = ADDR_W16 + 1;

   logic [3:0]     pins_s;
   logic           cs_s;
   logic           scl_s;
   logic           di_s;
   logic           org_s;
   logic           busy;
   logic           wen;
   logic           wr_one;
   logic           wr_all;
   logic [AW8-1:0] rd_adr;
   logic [AW8-1:0] wr_adr;
   logic [15:0]    wr_dat;
   logic [7:0]     rd_byte;

   generate
      if (ADDR_W16 < 2 || ADDR_W16 > 10) begin : g_bad_aw
         $error("serial_eeprom_slave: ADDR_W16 must lie in 2..10");
      end
   endgenerate

   ee_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({org, di, scl, cs}),
      .q     (pins_s)
   );

   assign {org_s, di_s, scl_s, cs_s} = pins_s;

   ee_ctrl #(.AW16(ADDR_W16)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_s    (cs_s),
      .scl_s   (scl_s),
      .di_s    (di_s),
      .org     (org_s),
      .busy    (busy),
      .rd_byte (rd_byte),
      .rd_adr  (rd_adr),
      .wr_adr  (wr_adr),
      .wr_dat  (wr_dat),
      .wr_one  (wr_one),
      .wr_all  (wr_all),
      .wen     (wen),
      .do_q    (do_o),
      .do_oe   (do_oe)
   );

   ee_array #(.AW8(AW8)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_one  (wr_one),
      .wr_all  (wr_all),
      .wide    (org_s),
      .wr_adr  (wr_adr),
      .wr_dat  (wr_dat),
      .rd_adr  (rd_adr),
      .rd_byte (rd_byte)
   );

   ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_one | wr_all),
      .busy  (busy)
   );

endmodule

module ee_checker #(
   parameter int PROG_CYCLES = 1
) (
   input logic clk,
   input logic rst_n,
   input logic cs,
   input logic do_oe,
   input logic busy,
   input logic wen,
   input logic wr_one,
   input logic wr_all
);

   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   a_r11_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cs, 1) && !$past(cs, 2) && !$past(cs, 3) && !$past(cs, 4)) |-> !do_oe);

   a_r10_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == PROG_CYCLES));

   a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wen) |-> !(wr_one || wr_all));

   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> !(wr_one || wr_all));

endmodule

bind serial_eeprom_slave ee_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs     (cs),
   .do_oe  (do_oe),
   .busy   (busy),
   .wen    (wen),
   .wr_one (wr_one),
   .wr_all (wr_all)
);

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;

   localparam int AW16 = 4;
   localparam int AW8  = AW16 + 1;
   localparam int NW   = 1 << AW16;
   localparam int NB   = 1 << AW8;
   localparam int PC   = 60;
   localparam int H    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic scl = 1'b0;
   logic di = 1'b0;
   logic org = 1'b1;
   logic do_o;
   logic do_oe;

   int errors = 0;
   int checks = 0;
   logic [7:0] mdl [NB];

   always #2 clk = ~clk;

   serial_eeprom_slave #(.ADDR_W16(AW16), .PROG_CYCLES(PC), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .scl(scl), .di(di), .org(org),
      .do_o(do_o), .do_oe(do_oe)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic b, output logic o);
      di = b;
      tick(H);
      scl = 1'b1;
      tick(H);
      o = do_o;
      scl = 1'b0;
   endtask

   task automatic cs_up;
      scl = 1'b0;
      tick(H);
      cs = 1'b1;
      tick(H);
   endtask

   task automatic cs_down;
      cs = 1'b0;
      di = 1'b0;
      tick(H);
   endtask

   function automatic int na();
      return org ? AW16 : AW8;
   endfunction

   function automatic int nd();
      return org ? 16 : 8;
   endfunction

   function automatic logic [15:0] exp_at(input int a);
      if (org) return {mdl[(2*a) % NB], mdl[(2*a+1) % NB]};
      return {8'h00, mdl[a % NB]};
   endfunction

   task automatic head(input logic [1:0] op, input logic [15:0] adr, output logic last);
      logic o;
      pulse(1'b1, o);
      pulse(op[1], o);
      pulse(op[0], o);
      for (int i = na() - 1; i >= 0; i--) pulse(adr[i], o);
      last = o;
   endtask

   task automatic body(input logic [15:0] d);
      logic o;
      for (int i = nd() - 1; i >= 0; i--) pulse(d[i], o);
   endtask

   task automatic prog(input logic [1:0] op, input logic [15:0] adr, input bit has_dat,
                       input logic [15:0] d, input bit exp_busy, input string tag);
      logic o;
      int n;
      cs_up;
      head(op, adr, o);
      if (has_dat) body(d);
      cs_down;
      cs_up;
      if (exp_busy) begin
         chk({"R11 status enable ", tag}, {15'b0, do_oe}, 16'd1);
         chk({"R11 busy shows 0 ", tag}, {15'b0, do_o}, 16'd0);
         n = 0;
         while (do_o !== 1'b1 && n < 500) begin
            tick(1);
            n++;
         end
         chk({"R10 ready within cycle ", tag}, {15'b0, (n > 0 && n <= PC)}, 16'd1);
         chk({"R11 ready shows 1 ", tag}, {15'b0, do_o}, 16'd1);
      end else begin
         chk({"R5 no program cycle ", tag}, {15'b0, do_oe}, 16'd0);
      end
      cs_down;
   endtask

   task automatic special(input logic [1:0] sel);
      logic [15:0] a;
      logic o;
      a = '0;
      a[na()-1] = sel[1];
      a[na()-2] = sel[0];
      cs_up;
      head(2'b00, a, o);
      cs_down;
   endtask

   task automatic rd(input int start, input int cnt, input int lead, input string tag);
      logic o;
      logic [15:0] w;
      int lim;
      lim = org ? NW : NB;
      cs_up;
      for (int i = 0; i < lead; i++) pulse(1'b0, o);
      head(2'b10, 16'(start), o);
      chk({"R3 dummy zero ", tag}, {15'b0, o}, 16'd0);
      chk({"R3 output enabled ", tag}, {15'b0, do_oe}, 16'd1);
      for (int k = 0; k < cnt; k++) begin
         w = '0;
         for (int b = 0; b < nd(); b++) begin
            pulse(1'b0, o);
            w = {w[14:0], o};
         end
         chk((k == 0) ? tag : {"R4 sequential ", tag}, w, exp_at((start + k) % lim));
      end
      cs_down;
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      chk("R11 reset enable low", {15'b0, do_oe}, 16'd0);
      chk("R11 reset output low", {15'b0, do_o}, 16'd0);

      org = 1'b1;
      tick(H);
      rd(0, 1, 3, "R1 R8 reset word with leading zeros");

      prog(2'b01, 16'd2, 1'b1, 16'h1234, 1'b0, "R5 locked store");
      rd(2, 1, 0, "R5 locked store left word");

      special(2'b11);
      for (int a = 0; a < NW; a++) begin
         d = 16'(a * 16'h1357) ^ 16'hA5C3;
         prog(2'b01, 16'(a), 1'b1, d, 1'b1, "R7 sweep");
         mdl[2*a]   = d[15:8];
         mdl[2*a+1] = d[7:0];
      end
      rd(5, NW + 1, 0, "R7 word sweep");

      org = 1'b0;
      tick(H);
      rd(0, NB + 1, 0, "R2 byte view");

      prog(2'b01, 16'd7, 1'b1, 16'h003C, 1'b1, "R2 byte store");
      mdl[7] = 8'h3C;
      prog(2'b11, 16'd4, 1'b0, 16'h0000, 1'b1, "R8 byte erase");
      mdl[4] = 8'hFF;
      org = 1'b1;
      tick(H);
      rd(3, 1, 0, "R2 word holds stored byte");
      rd(2, 1, 0, "R8 word after byte erase");
      prog(2'b11, 16'd9, 1'b0, 16'h0000, 1'b1, "R8 word erase");
      mdl[18] = 8'hFF;
      mdl[19] = 8'hFF;
      rd(8, 3, 0, "R8 erased word");

      begin
         logic o;
         cs_up;
         head(2'b01, 16'd1, o);
         body(16'hBEEF);
         cs_down;
         cs_up;
         head(2'b01, 16'd1, o);
         body(16'h0000);
         cs_down;
         mdl[2] = 8'hBE;
         mdl[3] = 8'hEF;
         tick(PC + 20);
         rd(1, 1, 0, "R10 command during busy ignored");

         cs_up;
         head(2'b01, 16'd6, o);
         for (int i = 0; i < 5; i++) pulse(1'b1, o);
         cs_down;
         cs_up;
         chk("R12 cancelled store starts no cycle", {15'b0, do_oe}, 16'd0);
         cs_down;
         rd(6, 1, 0, "R12 cancelled store left word");
      end

      prog(2'b00, 16'b0100 << (AW16 - 4), 1'b0, 16'h0000, 1'b1, "R8 whole erase");
      for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
      org = 1'b0;
      tick(H);
      rd(0, NB, 0, "R8 whole erase bytes");

      prog(2'b00, 16'b10000 << (AW8 - 5), 1'b1, 16'h005A, 1'b1, "R9 whole store bytes");
      for (int i = 0; i < NB; i++) mdl[i] = 8'h5A;
      rd(0, NB, 0, "R9 whole store bytes");

      org = 1'b1;
      tick(H);
      prog(2'b00, 16'b1000 << (AW16 - 4), 1'b1, 16'hC33C, 1'b1, "R9 whole store words");
      for (int i = 0; i < NW; i++) begin
         mdl[2*i]   = 8'hC3;
         mdl[2*i+1] = 8'h3C;
      end
      rd(0, NW, 0, "R9 whole store words");

      special(2'b00);
      prog(2'b01, 16'd0, 1'b1, 16'h1111, 1'b0, "R6 store after lock");
      prog(2'b11, 16'd3, 1'b0, 16'h0000, 1'b0, "R6 erase after lock");
      rd(0, 4, 0, "R6 read while locked");

      finish_run();
   end

endmodule